// File: doc/BRIEF.md
# Threshold-Triggered Serial-Port FIFO Pair

This block holds the byte queues that sit between a serial shift engine and the system bus. It has one queue for each direction. The transmit queue is filled from the bus and drained by the shifter. The receive queue is filled by the shifter and drained by the bus. Each queue has a fill threshold that software programs. A threshold crossing raises a sticky interrupt status bit. If the DMA request for that direction is enabled, the crossing also drives a DMA request line.

A small word-wide register port gives access to four words:

- a FIFO control word holding both thresholds, both DMA enables and two self-clearing queue resets;
- a read-only occupancy word;
- an interrupt enable word;
- a write-one-to-clear interrupt status word.

The status word also records receive overflow and a transfer-complete pulse from the shifter. The interrupt line is the enabled subset of the status bits, ORed together. Queue depth is a parameter and must be 64 or 128.

Top module: `spi_fifo_pair`

## Requirements
- R1: Register addresses are 0 for FIFO control, 1 for FIFO status, 2 for interrupt enable and 3 for interrupt status. While reset is held, all four words read 0, and irq, tx_dreq, rx_dreq and shf_tx_avail are 0.
- R2: Each queue returns bytes in the order they were pushed. The FIFO status word holds the receive occupancy in bits 7:0 and the transmit occupancy in bits 23:16. A push to a full transmit queue is ignored. A pop from an empty queue is ignored, and the data output of an empty queue reads 0.
- R3: A push and a pop on the same edge are both accepted, even when the queue is full. The occupancy stays the same and no overflow is recorded.
- R4: A shifter push to a full receive queue without a pop in the same cycle drops the byte. The same edge sets interrupt status bit 8, and the bit stays set until it is cleared.
- R5: Interrupt status bit 0 sets on the edge after the receive occupancy becomes at least the receive trigger level (FIFO control bits 7:0).
- R6: Interrupt status bit 4 sets on the edge after the transmit occupancy becomes at most the transmit trigger level (FIFO control bits 23:16).
- R7: Writing address 3 clears each status bit written as 1. A bit whose condition still holds stays set. A xfer_done pulse sets bit 12.
- R8: irq is the OR of the status bits ANDed with the interrupt enable word. The enable word stores only bits 0, 4, 8 and 12 and reads 0 elsewhere.
- R9: rx_dreq is high when FIFO control bit 8 is set, the receive occupancy is at least its trigger level and the receive queue is not empty. tx_dreq is high when bit 24 is set, the transmit occupancy is at most its trigger level and the transmit queue is not full. Both follow the occupancy in the same cycle.
- R10: Writing FIFO control with bit 15 set empties the receive queue on that edge. Writing it with bit 31 set empties the transmit queue. The other queue is unaffected, both reset bits read back as 0, and the other fields of the same write are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| bus_tx_wr | input | 1 | Bus push into the transmit queue |
| bus_tx_data | input | 8 | Byte to push into the transmit queue |
| bus_rx_rd | input | 1 | Bus pop from the receive queue |
| bus_rx_data | output | 8 | Head of the receive queue (0 when empty) |
| shf_tx_pop | input | 1 | Shifter pop from the transmit queue |
| shf_tx_data | output | 8 | Head of the transmit queue (0 when empty) |
| shf_tx_avail | output | 1 | Transmit queue not empty |
| shf_rx_push | input | 1 | Shifter push into the receive queue |
| shf_rx_data | input | 8 | Byte to push into the receive queue |
| xfer_done | input | 1 | Transfer-complete pulse from the shifter |
| irq | output | 1 | Interrupt request |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |

## Verification
Two pairs of functions can fall in the same cycle:

- A shifter push can meet a bus pop while the receive queue is full. This is provoked by driving both strobes on one edge with 64 bytes held. It is judged by the unchanged occupancy, the absence of overflow status, and the new byte emerging last after 63 older ones.
- A write-one-to-clear can meet a still-true threshold condition. This is provoked by clearing the transmit request bit while the occupancy sits at the trigger level. It is judged by the bit reading back as set, and by the bit reading back as cleared once the occupancy has moved above the level.

// File: rtl/spi_fifo_pair_pkg.sv
package spi_fifo_pair_pkg;

   localparam int unsigned REG_AW = 2;
   localparam logic [REG_AW-1:0] A_FCTL = 2'd0;
   localparam logic [REG_AW-1:0] A_FSTA = 2'd1;
   localparam logic [REG_AW-1:0] A_IEN  = 2'd2;
   localparam logic [REG_AW-1:0] A_ISTA = 2'd3;

   localparam int unsigned RXTRIG_LSB = 0;
   localparam int unsigned RXDMA_BIT  = 8;
   localparam int unsigned RXRST_BIT  = 15;
   localparam int unsigned TXTRIG_LSB = 16;
   localparam int unsigned TXDMA_BIT  = 24;
   localparam int unsigned TXRST_BIT  = 31;
   localparam int unsigned TRIG_W     = 8;

   localparam int unsigned NEV = 4;
   localparam int unsigned EV_RXRDY = 0;
   localparam int unsigned EV_TXREQ = 1;
   localparam int unsigned EV_RXOVF = 2;
   localparam int unsigned EV_DONE  = 3;

   typedef enum logic { CMP_AT_LEAST = 1'b0, CMP_AT_MOST = 1'b1 } cmp_dir_e;

   function automatic int unsigned ev_pos(input int unsigned idx);
      return idx * 4;
   endfunction

   function automatic logic [31:0] ev_to_word(input logic [NEV-1:0] ev);
      logic [31:0] w;
      w = '0;
      for (int k = 0; k < NEV; k++) w[ev_pos(k)] = ev[k];
      return w;
   endfunction

   function automatic logic [NEV-1:0] word_to_ev(input logic [31:0] w);
      logic [NEV-1:0] ev;
      for (int k = 0; k < NEV; k++) ev[k] = w[ev_pos(k)];
      return ev;
   endfunction

endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned WIDTH = 8,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty,
   output logic             drop
);

   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
         $error("sfp_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [CW-1:0]    cnt;
   logic             push_ok, pop_ok;

   assign empty    = (cnt == '0);
   assign full     = (cnt == CW'(DEPTH));
   assign pop_ok   = pop & ~empty;
   assign push_ok  = push & (~full | pop_ok);
   assign drop     = push & ~push_ok;
   assign count    = cnt;
   assign pop_data = empty ? '0 : mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (srst) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (push_ok) wptr <= wptr + AW'(1);
         if (pop_ok)  rptr <= rptr + AW'(1);
         cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !srst) mem[wptr] <= push_data;
   end

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   p_simul_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !empty && !srst) |=> $stable(count));
   p_drop_only_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drop |-> (full && !pop));
   p_srst_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> empty);

endmodule

// File: rtl/sfp_level.sv
module sfp_level
   import spi_fifo_pair_pkg::*;
#(
   parameter int unsigned CW  = 7,
   parameter cmp_dir_e    DIR = CMP_AT_LEAST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     count,
   input  logic [TRIG_W-1:0] trig,
   input  logic              full,
   input  logic              empty,
   input  logic              dma_en,
   output logic              hit,
   output logic              dreq
);

   generate
      if (CW > TRIG_W) begin : g_bad_cw
         $error("sfp_level: count wider than trigger field");
      end
      if (DIR == CMP_AT_LEAST) begin : g_fill
         assign hit  = (TRIG_W'(count) >= trig);
         assign dreq = dma_en & hit & ~empty;
         p_rx_dreq_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
            dreq |-> (count != '0));
      end else begin : g_drain
         assign hit  = (TRIG_W'(count) <= trig);
         assign dreq = dma_en & hit & ~full;
         p_tx_dreq_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
            dreq |-> !full);
      end
   endgenerate

endmodule

// File: rtl/sfp_irq.sv
module sfp_irq
   import spi_fifo_pair_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] set_ev,
   input  logic           clr_we,
   input  logic [NEV-1:0] clr_mask,
   input  logic           en_we,
   input  logic [NEV-1:0] en_data,
   output logic [NEV-1:0] sta,
   output logic [NEV-1:0] en,
   output logic           irq
);

   logic [NEV-1:0] clr_eff;
   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sta <= '0;
         en  <= '0;
      end else begin
         sta <= (sta & ~clr_eff) | set_ev;
         if (en_we) en <= en_data;
      end
   end

   assign irq = |(sta & en);

   generate
      for (genvar k = 0; k < NEV; k++) begin : g_ev
         p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[k] |=> sta[k]);
         p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_eff[k] && !set_ev[k]) |=> !sta[k]);
         p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (sta[k] && !clr_eff[k]) |=> sta[k]);
         p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sta[k] && en[k]) |-> irq);
      end
   endgenerate

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
   import spi_fifo_pair_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              bus_tx_wr,
   input  logic [7:0]        bus_tx_data,
   input  logic              bus_rx_rd,
   output logic [7:0]        bus_rx_data,
   input  logic              shf_tx_pop,
   output logic [7:0]        shf_tx_data,
   output logic              shf_tx_avail,
   input  logic              shf_rx_push,
   input  logic [7:0]        shf_rx_data,
   input  logic              xfer_done,
   output logic              irq,
   output logic              tx_dreq,
   output logic              rx_dreq
);

   generate
      if (DEPTH != 64 && DEPTH != 128) begin : g_bad_depth
         $error("spi_fifo_pair: DEPTH must be 64 or 128");
      end
   endgenerate

   logic [TRIG_W-1:0] rx_trig, tx_trig;
   logic              rx_dma_en, tx_dma_en;
   logic              fctl_we, ien_we, ista_we;
   logic              rx_srst, tx_srst;
   logic [CW-1:0]     rx_cnt, tx_cnt;
   logic              rx_full, rx_empty, rx_drop;
   logic              tx_full, tx_empty, tx_drop;
   logic              rx_hit, tx_hit;
   logic [NEV-1:0]    set_ev, ista, ien;
   logic              wdata_unused;

   assign fctl_we = reg_wr && (reg_addr == A_FCTL);
   assign ien_we  = reg_wr && (reg_addr == A_IEN);
   assign ista_we = reg_wr && (reg_addr == A_ISTA);
   assign rx_srst = fctl_we && reg_wdata[RXRST_BIT];
   assign tx_srst = fctl_we && reg_wdata[TXRST_BIT];
   assign wdata_unused = ^{reg_wdata[14:13], reg_wdata[11:9], reg_wdata[30:25]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_trig   <= '0;
         tx_trig   <= '0;
         rx_dma_en <= 1'b0;
         tx_dma_en <= 1'b0;
      end else if (fctl_we) begin
         rx_trig   <= reg_wdata[RXTRIG_LSB +: TRIG_W];
         tx_trig   <= reg_wdata[TXTRIG_LSB +: TRIG_W];
         rx_dma_en <= reg_wdata[RXDMA_BIT];
         tx_dma_en <= reg_wdata[TXDMA_BIT];
      end
   end

   sfp_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
      .clk(clk), .rst_n(rst_n), .srst(tx_srst),
      .push(bus_tx_wr), .push_data(bus_tx_data),
      .pop(shf_tx_pop), .pop_data(shf_tx_data),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty), .drop(tx_drop)
   );

   sfp_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
      .clk(clk), .rst_n(rst_n), .srst(rx_srst),
      .push(shf_rx_push), .push_data(shf_rx_data),
      .pop(bus_rx_rd), .pop_data(bus_rx_data),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty), .drop(rx_drop)
   );

   sfp_level #(.CW(CW), .DIR(CMP_AT_LEAST)) u_rxlvl (
      .clk(clk), .rst_n(rst_n), .count(rx_cnt), .trig(rx_trig),
      .full(rx_full), .empty(rx_empty), .dma_en(rx_dma_en),
      .hit(rx_hit), .dreq(rx_dreq)
   );

   sfp_level #(.CW(CW), .DIR(CMP_AT_MOST)) u_txlvl (
      .clk(clk), .rst_n(rst_n), .count(tx_cnt), .trig(tx_trig),
      .full(tx_full), .empty(tx_empty), .dma_en(tx_dma_en),
      .hit(tx_hit), .dreq(tx_dreq)
   );

   always_comb begin
      set_ev           = '0;
      set_ev[EV_RXRDY] = rx_hit;
      set_ev[EV_TXREQ] = tx_hit;
      set_ev[EV_RXOVF] = rx_drop & ~rx_srst;
      set_ev[EV_DONE]  = xfer_done;
   end

   sfp_irq u_irq (
      .clk(clk), .rst_n(rst_n), .set_ev(set_ev),
      .clr_we(ista_we), .clr_mask(word_to_ev(reg_wdata)),
      .en_we(ien_we), .en_data(word_to_ev(reg_wdata)),
      .sta(ista), .en(ien), .irq(irq)
   );

   assign shf_tx_avail = ~tx_empty;

   always_comb begin
      case (reg_addr)
         A_FCTL:  reg_rdata = {1'b0, 6'b0, tx_dma_en, tx_trig,
                               1'b0, 6'b0, rx_dma_en, rx_trig};
         A_FSTA:  reg_rdata = {8'b0, 8'(tx_cnt), 8'b0, 8'(rx_cnt)};
         A_IEN:   reg_rdata = ev_to_word(ien);
         default: reg_rdata = ev_to_word(ista);
      endcase
   end

   p_rx_srst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_srst |=> (rx_cnt == '0));
   p_tx_srst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_srst |=> (tx_cnt == '0));
   p_tx_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && !shf_tx_pop && !tx_srst) |=> tx_full);
   p_ovf_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_drop && !rx_srst) |=> ista[EV_RXOVF]);
   p_tx_drop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_drop |=> !$rose(ista[EV_RXOVF]) || $past(rx_drop));

endmodule

// File: tb/spi_fifo_pair_tb_top.sv
module spi_fifo_pair_tb_top;

   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        bus_tx_wr = 1'b0;
   logic [7:0]  bus_tx_data = '0;
   logic        bus_rx_rd = 1'b0;
   logic [7:0]  bus_rx_data;
   logic        shf_tx_pop = 1'b0;
   logic [7:0]  shf_tx_data;
   logic        shf_tx_avail;
   logic        shf_rx_push = 1'b0;
   logic [7:0]  shf_rx_data = '0;
   logic        xfer_done = 1'b0;
   logic        irq, tx_dreq, rx_dreq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   spi_fifo_pair #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .bus_tx_wr(bus_tx_wr), .bus_tx_data(bus_tx_data),
      .bus_rx_rd(bus_rx_rd), .bus_rx_data(bus_rx_data),
      .shf_tx_pop(shf_tx_pop), .shf_tx_data(shf_tx_data),
      .shf_tx_avail(shf_tx_avail),
      .shf_rx_push(shf_rx_push), .shf_rx_data(shf_rx_data),
      .xfer_done(xfer_done), .irq(irq), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
   );

   function automatic logic [7:0] txb(input int i); return 8'((i * 37 + 5) & 255); endfunction
   function automatic logic [7:0] rxb(input int i); return 8'((i * 11 + 3) & 255); endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0; #1;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic tx_push(input logic [7:0] d);
      @(negedge clk); bus_tx_wr = 1'b1; bus_tx_data = d;
      @(negedge clk); bus_tx_wr = 1'b0; #1;
   endtask

   task automatic tx_pop();
      @(negedge clk); shf_tx_pop = 1'b1;
      @(negedge clk); shf_tx_pop = 1'b0; #1;
   endtask

   task automatic rx_push(input logic [7:0] d);
      @(negedge clk); shf_rx_push = 1'b1; shf_rx_data = d;
      @(negedge clk); shf_rx_push = 1'b0; #1;
   endtask

   task automatic rx_pop();
      @(negedge clk); bus_rx_rd = 1'b1;
      @(negedge clk); bus_rx_rd = 1'b0; #1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic pulse_done();
      @(negedge clk); xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0; #1;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   localparam logic [31:0] CTL_BASE = 32'd4 | (32'd2 << 16) | (32'd1 << 8) | (32'd1 << 24);

   initial begin
      logic [31:0] d;
      int cnt;

      // R1 reset state
      idle(3);
      for (int a = 0; a < 4; a++) begin
         reg_read(2'(a), d);
         check($sformatf("R1 reg %0d in reset", a), d, 32'h0);
      end
      check("R1 irq in reset", {31'b0, irq}, 32'h0);
      check("R1 dreqs in reset", {30'b0, tx_dreq, rx_dreq}, 32'h0);
      check("R1 tx avail in reset", {31'b0, shf_tx_avail}, 32'h0);
      rst_n = 1'b1;
      idle(2);

      reg_write(2'd0, CTL_BASE);
      reg_read(2'd0, d);
      check("R10 control readback", d, CTL_BASE);

      // R2 R9 transmit fill sweep
      for (int i = 0; i < DEPTH; i++) begin
         tx_push(txb(i));
         reg_read(2'd1, d);
         check($sformatf("R2 tx count after push %0d", i), {24'b0, d[23:16]}, 32'(i + 1));
         check($sformatf("R9 tx_dreq at count %0d", i + 1), {31'b0, tx_dreq},
               {31'b0, ((i + 1) <= 2)});
      end
      tx_push(8'hAA);
      reg_read(2'd1, d);
      check("R2 push to full tx ignored", {24'b0, d[23:16]}, 32'(DEPTH));
      for (int i = 0; i < DEPTH; i++) begin
         check($sformatf("R2 tx order %0d", i), {24'b0, shf_tx_data}, {24'b0, txb(i)});
         tx_pop();
         cnt = DEPTH - 1 - i;
         reg_read(2'd1, d);
         check($sformatf("R2 tx count after pop %0d", i), {24'b0, d[23:16]}, 32'(cnt));
         check($sformatf("R9 tx_dreq drain at %0d", cnt), {31'b0, tx_dreq}, {31'b0, (cnt <= 2)});
      end
      check("R2 empty tx data reads zero", {24'b0, shf_tx_data}, 32'h0);
      tx_pop();
      reg_read(2'd1, d);
      check("R2 pop from empty tx ignored", {24'b0, d[23:16]}, 32'h0);

      // R6 R7 transmit request status and clear against live condition
      for (int i = 0; i < 5; i++) tx_push(8'(100 + i));
      idle(1);
      reg_write(2'd3, 32'hFFFF_FFFF);
      reg_read(2'd3, d);
      check("R7 clear all with conditions false", d, 32'h0);
      for (int i = 0; i < 3; i++) tx_pop();
      idle(1);
      reg_read(2'd3, d);
      check("R6 tx request bit at level", d, 32'h10);
      reg_write(2'd3, 32'h10);
      reg_read(2'd3, d);
      check("R7 clear while condition true keeps bit", d, 32'h10);
      tx_push(8'h77);
      reg_write(2'd3, 32'h10);
      reg_read(2'd3, d);
      check("R7 clear after condition false", d, 32'h0);

      // R5 R9 receive fill sweep
      for (int i = 0; i < DEPTH; i++) begin
         rx_push(rxb(i));
         check($sformatf("R9 rx_dreq at count %0d", i + 1), {31'b0, rx_dreq},
               {31'b0, ((i + 1) >= 4)});
         idle(1);
         reg_read(2'd1, d);
         check($sformatf("R2 rx count after push %0d", i), {24'b0, d[7:0]}, 32'(i + 1));
         reg_read(2'd3, d);
         check($sformatf("R5 rx ready bit at count %0d", i + 1), {31'b0, d[0]},
               {31'b0, ((i + 1) >= 4)});
      end

      // R4 overflow
      reg_read(2'd3, d);
      check("R4 no overflow before extra push", {31'b0, d[8]}, 32'h0);
      rx_push(8'h5A);
      reg_read(2'd3, d);
      check("R4 overflow bit set", {31'b0, d[8]}, 32'h1);
      reg_read(2'd1, d);
      check("R4 rx count stays full", {24'b0, d[7:0]}, 32'(DEPTH));
      idle(2);
      reg_read(2'd3, d);
      check("R4 overflow sticky", {31'b0, d[8]}, 32'h1);
      reg_write(2'd3, 32'h100);
      reg_read(2'd3, d);
      check("R7 overflow cleared", {31'b0, d[8]}, 32'h0);

      // R3 push and pop together at full
      @(negedge clk); shf_rx_push = 1'b1; shf_rx_data = 8'hC3; bus_rx_rd = 1'b1;
      #1 check("R3 head before simultaneous", {24'b0, bus_rx_data}, {24'b0, rxb(0)});
      @(negedge clk); shf_rx_push = 1'b0; bus_rx_rd = 1'b0; #1;
      reg_read(2'd1, d);
      check("R3 count unchanged", {24'b0, d[7:0]}, 32'(DEPTH));
      reg_read(2'd3, d);
      check("R3 no overflow on simultaneous", {31'b0, d[8]}, 32'h0);
      for (int i = 1; i <= DEPTH; i++) begin
         check($sformatf("R2 rx order %0d", i), {24'b0, bus_rx_data},
               {24'b0, (i == DEPTH) ? 8'hC3 : rxb(i)});
         rx_pop();
      end
      reg_read(2'd1, d);
      check("R2 rx drained", {24'b0, d[7:0]}, 32'h0);
      check("R2 empty rx data reads zero", {24'b0, bus_rx_data}, 32'h0);

      // R8 interrupt gating, R7 transfer complete
      reg_write(2'd2, 32'hFFFF_FFFF);
      reg_read(2'd2, d);
      check("R8 enable word bits", d, 32'h1111);
      reg_write(2'd3, 32'hFFFF_FFFF);
      reg_read(2'd3, d);
      check("R7 all cleared", d, 32'h0);
      check("R8 irq low with no status", {31'b0, irq}, 32'h0);
      pulse_done();
      reg_read(2'd3, d);
      check("R7 done bit set", d, 32'h1000);
      check("R8 irq high with done enabled", {31'b0, irq}, 32'h1);
      reg_write(2'd2, 32'h1);
      check("R8 irq low with done masked", {31'b0, irq}, 32'h0);
      reg_write(2'd2, 32'h1000);
      check("R8 irq high again", {31'b0, irq}, 32'h1);
      reg_write(2'd3, 32'h1000);
      reg_read(2'd3, d);
      check("R7 done cleared", d, 32'h0);
      check("R8 irq low after clear", {31'b0, irq}, 32'h0);

      // R9 trigger sweep with rx=5, tx=3
      for (int i = 0; i < 5; i++) rx_push(rxb(i));
      for (int t = 0; t <= 70; t++) begin
         reg_write(2'd0, 32'(t) | (32'(t) << 16) | (32'd1 << 8) | (32'd1 << 24));
         check($sformatf("R9 rx_dreq trig %0d", t), {31'b0, rx_dreq}, {31'b0, (5 >= t)});
         check($sformatf("R9 tx_dreq trig %0d", t), {31'b0, tx_dreq}, {31'b0, (3 <= t)});
      end
      reg_write(2'd0, 32'h0);
      check("R9 dreqs off when disabled", {30'b0, tx_dreq, rx_dreq}, 32'h0);

      // R10 soft resets
      reg_write(2'd0, CTL_BASE | (32'd1 << 15));
      reg_read(2'd1, d);
      check("R10 rx reset empties only rx", d, 32'h0003_0000);
      reg_read(2'd0, d);
      check("R10 rx reset bit reads zero", d, CTL_BASE);
      reg_write(2'd0, CTL_BASE | (32'd1 << 31));
      reg_read(2'd1, d);
      check("R10 tx reset empties tx", d, 32'h0);
      reg_read(2'd0, d);
      check("R10 tx reset bit reads zero", d, CTL_BASE);

      // R9 boundaries: full tx and empty rx with extreme triggers
      reg_write(2'd0, 32'h0 | (32'd255 << 16) | (32'd1 << 8) | (32'd1 << 24));
      check("R9 rx_dreq low when empty at trig 0", {31'b0, rx_dreq}, 32'h0);
      for (int i = 0; i < DEPTH - 1; i++) tx_push(txb(i));
      check("R9 tx_dreq high one below full", {31'b0, tx_dreq}, 32'h1);
      tx_push(8'h11);
      check("R9 tx_dreq low when full", {31'b0, tx_dreq}, 32'h0);

      summary();
   end

endmodule